// File: doc/BRIEF.md
# Fused multiply-add special-operand resolver

This combinational block sits in front of a single-precision fused multiply-add that computes z + (x * y). It sorts each of the three 32-bit operands into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. It applies two independent sign controls, one that negates the product and one that negates the addend. It then decides whether the answer is fixed by the operand classes alone.

When the answer is fixed, the block raises a bypass flag and supplies the finished 32-bit result, together with the invalid-operation flag. The fixed answers are a propagated or default NaN, a signed infinity, a signed zero, or the addend itself. When neither the flag nor a result can be decided from the classes, the bypass flag is low. In that case the numeric datapath takes over, using the effective product and addend signs that this block also drives.

Rounding of finite sums is not done here. Subnormal inputs count as finite nonzero values; they are not flushed.

Top module: `fma_special_resolver`

## Requirements
- R1: `prod_sign_o` always equals sign(x) XOR sign(y) XOR `neg_prod_i`, and `add_sign_o` always equals sign(z) XOR `neg_add_i`, for every operand class.
- R2: A signalling NaN (exponent all ones, mantissa nonzero, mantissa bit 22 clear) wins over every other operand. Among signalling NaNs, z is chosen first, then x, then y. The result is that operand with mantissa bit 22 set, the bypass flag is high and invalid is high.
- R3: With no signalling NaN present, a quiet NaN (exponent all ones, mantissa bit 22 set) is returned bit for bit unchanged, with invalid low. Among quiet NaNs, z is chosen first, then x, then y.
- R4: With no NaN present, an infinity multiplied by a zero, in either operand order, returns 0x7FC00000 with invalid high.
- R5: With no NaN present, an infinite product added to an infinite z whose effective sign differs from the product sign returns 0x7FC00000 with invalid high.
- R6: Any other infinite product, with no NaN present, returns an infinity carrying the product sign (0x7F800000 or 0xFF800000), with invalid low.
- R7: A zero product with an infinite or nonzero finite z returns z's exponent and mantissa with the effective addend sign, with invalid low.
- R8: A zero product with a zero z returns a zero. If the product and effective addend signs match, the zero takes that shared sign. If they differ, the result is +0, except when `rnd_mode_i` is 3 (toward minus infinity), where it is -0. The rounding mode is coded as 0 nearest, 1 toward zero, 2 up and 3 down.
- R9: A finite nonzero product (either factor may be subnormal) with an infinite z returns an infinity carrying the effective addend sign, with invalid low.
- R10: The bypass flag is low exactly when x and y are both finite and nonzero and z is finite. In that case the result output is 0 and invalid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 32 | First multiplicand |
| y_i | input | 32 | Second multiplicand |
| z_i | input | 32 | Addend |
| neg_prod_i | input | 1 | Invert the product sign |
| neg_add_i | input | 1 | Invert the addend sign |
| rnd_mode_i | input | 2 | Rounding mode: 0 nearest, 1 toward zero, 2 up, 3 down |
| bypass_valid_o | output | 1 | Result is fixed by operand classes |
| bypass_result_o | output | 32 | Fixed result, 0 when bypass is low |
| invalid_o | output | 1 | Invalid-operation flag |
| prod_sign_o | output | 1 | Effective product sign |
| add_sign_o | output | 1 | Effective addend sign |

## Verification
The immediate assertions assume that all inputs are settled, two-state values, so they treat every bit pattern as a legal operand. The stimulus holds each operand stable for a full clock period and samples away from the edge. It sweeps every combination of twelve representative encodings for x, y and z: both signs of each of the six classes, with distinct NaN payloads so that the priority between operands is visible in the result. Each of these combinations is run under all four pairings of the negate controls and all four rounding modes.

// File: rtl/fma_spec_pkg.sv
package fma_spec_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUBN = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fp_cls_e;

  localparam int unsigned NUM_OPS = 3;
  // priority order of NaN selection is index order
  localparam int unsigned IDX_Z = 0;
  localparam int unsigned IDX_X = 1;
  localparam int unsigned IDX_Y = 2;

  localparam logic [1:0] RND_DOWN = 2'd3;

  function automatic logic cls_is_nan(fp_cls_e c);
    return (c == CLS_QNAN) || (c == CLS_SNAN);
  endfunction

  function automatic logic cls_is_zero(fp_cls_e c);
    return c == CLS_ZERO;
  endfunction

  function automatic logic cls_is_inf(fp_cls_e c);
    return c == CLS_INF;
  endfunction

  function automatic logic cls_is_finite_nz(fp_cls_e c);
    return (c == CLS_SUBN) || (c == CLS_NORM);
  endfunction

endpackage

// File: rtl/fma_operand_classifier.sv
module fma_operand_classifier
  import fma_spec_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned MAG_W = EXP_W + MAN_W
) (
  input  logic [MAG_W-1:0] mag_i,
  output fp_cls_e          cls_o
);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max, exp_min, man_nz, quiet_bit;

  assign exp_f     = mag_i[MAG_W-1:MAN_W];
  assign man_f     = mag_i[MAN_W-1:0];
  assign exp_max   = &exp_f;
  assign exp_min   = ~|exp_f;
  assign man_nz    = |man_f;
  assign quiet_bit = man_f[MAN_W-1];

  always_comb begin
    if (exp_max) begin
      if (!man_nz)        cls_o = CLS_INF;
      else if (quiet_bit) cls_o = CLS_QNAN;
      else                cls_o = CLS_SNAN;
    end else if (exp_min) begin
      cls_o = man_nz ? CLS_SUBN : CLS_ZERO;
    end else begin
      cls_o = CLS_NORM;
    end
  end

endmodule

// File: rtl/fma_nan_selector.sv
module fma_nan_selector
  import fma_spec_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned WIDTH = 1 + EXP_W + MAN_W
) (
  input  logic    [NUM_OPS-1:0][WIDTH-1:0] ops_i,
  input  fp_cls_e [NUM_OPS-1:0]            cls_i,
  output logic                             nan_hit_o,
  output logic                             nan_sig_o,
  output logic    [WIDTH-1:0]              nan_val_o
);

  localparam logic [WIDTH-1:0] QUIET_MASK = WIDTH'(1) << (MAN_W - 1);

  // quiet pass first, signalling pass overrides; descending index so lowest index wins
  always_comb begin
    nan_hit_o = 1'b0;
    nan_sig_o = 1'b0;
    nan_val_o = '0;
    for (int i = NUM_OPS - 1; i >= 0; i--) begin
      if (cls_i[i] == CLS_QNAN) begin
        nan_hit_o = 1'b1;
        nan_val_o = ops_i[i];
      end
    end
    for (int i = NUM_OPS - 1; i >= 0; i--) begin
      if (cls_i[i] == CLS_SNAN) begin
        nan_hit_o = 1'b1;
        nan_sig_o = 1'b1;
        nan_val_o = ops_i[i] | QUIET_MASK;
      end
    end
  end

  always_comb begin
    if (nan_sig_o) begin
      AST_SIG_RESULT_QUIET: assert (nan_val_o[MAN_W-1] && nan_hit_o); // R2
    end
  end

endmodule

// File: rtl/fma_class_resolver.sv
module fma_class_resolver
  import fma_spec_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned MAG_W = EXP_W + MAN_W,
  localparam int unsigned WIDTH = 1 + MAG_W
) (
  input  fp_cls_e          x_cls_i,
  input  fp_cls_e          y_cls_i,
  input  fp_cls_e          z_cls_i,
  input  logic             prod_sign_i,
  input  logic             add_sign_i,
  input  logic [MAG_W-1:0] z_mag_i,
  input  logic [1:0]       rnd_mode_i,
  output logic             special_o,
  output logic             invalid_o,
  output logic [WIDTH-1:0] result_o
);

  localparam logic [WIDTH-1:0] DEF_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [MAG_W-1:0] INF_MAG = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};

  logic prod_inf, prod_zero, inf_times_zero;

  assign prod_inf       = cls_is_inf(x_cls_i)  || cls_is_inf(y_cls_i);
  assign prod_zero      = cls_is_zero(x_cls_i) || cls_is_zero(y_cls_i);
  assign inf_times_zero = prod_inf && prod_zero;

  // NaN operands are resolved upstream; this covers the remaining classes
  always_comb begin
    special_o = 1'b1;
    invalid_o = 1'b0;
    result_o  = '0;
    if (inf_times_zero) begin
      invalid_o = 1'b1;
      result_o  = DEF_NAN;
    end else if (prod_inf) begin
      if (cls_is_inf(z_cls_i) && (add_sign_i != prod_sign_i)) begin
        invalid_o = 1'b1;
        result_o  = DEF_NAN;
      end else begin
        result_o = {prod_sign_i, INF_MAG};
      end
    end else if (prod_zero) begin
      if (cls_is_zero(z_cls_i)) begin
        if (add_sign_i == prod_sign_i) result_o = {add_sign_i, {MAG_W{1'b0}}};
        else result_o = {(rnd_mode_i == RND_DOWN), {MAG_W{1'b0}}};
      end else begin
        result_o = {add_sign_i, z_mag_i};
      end
    end else if (cls_is_inf(z_cls_i)) begin
      result_o = {add_sign_i, INF_MAG};
    end else begin
      special_o = 1'b0;
    end
  end

  always_comb begin
    if (!cls_is_nan(z_cls_i) && cls_is_inf(z_cls_i) && !prod_inf && !prod_zero) begin
      AST_FINITE_PROD_INF_ADDEND: assert (special_o && !invalid_o &&
                                          result_o[WIDTH-2:0] == INF_MAG); // R9
    end
  end

endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
  import fma_spec_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned MAG_W = EXP_W + MAN_W,
  localparam int unsigned WIDTH = 1 + MAG_W
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [WIDTH-1:0] z_i,
  input  logic             neg_prod_i,
  input  logic             neg_add_i,
  input  logic [1:0]       rnd_mode_i,
  output logic             bypass_valid_o,
  output logic [WIDTH-1:0] bypass_result_o,
  output logic             invalid_o,
  output logic             prod_sign_o,
  output logic             add_sign_o
);

  localparam logic [WIDTH-1:0] DEF_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic    [NUM_OPS-1:0][WIDTH-1:0] ops;
  fp_cls_e [NUM_OPS-1:0]            op_cls;

  assign ops[IDX_Z] = z_i;
  assign ops[IDX_X] = x_i;
  assign ops[IDX_Y] = y_i;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
    fma_operand_classifier #(
      .EXP_W(EXP_W),
      .MAN_W(MAN_W)
    ) i_cls (
      .mag_i(ops[g][MAG_W-1:0]),
      .cls_o(op_cls[g])
    );
  end

  assign prod_sign_o = x_i[WIDTH-1] ^ y_i[WIDTH-1] ^ neg_prod_i;
  assign add_sign_o  = z_i[WIDTH-1] ^ neg_add_i;

  logic             nan_hit, nan_sig;
  logic [WIDTH-1:0] nan_val;

  fma_nan_selector #(
    .EXP_W(EXP_W),
    .MAN_W(MAN_W)
  ) i_nan (
    .ops_i    (ops),
    .cls_i    (op_cls),
    .nan_hit_o(nan_hit),
    .nan_sig_o(nan_sig),
    .nan_val_o(nan_val)
  );

  logic             cls_special, cls_invalid;
  logic [WIDTH-1:0] cls_result;

  fma_class_resolver #(
    .EXP_W(EXP_W),
    .MAN_W(MAN_W)
  ) i_res (
    .x_cls_i    (op_cls[IDX_X]),
    .y_cls_i    (op_cls[IDX_Y]),
    .z_cls_i    (op_cls[IDX_Z]),
    .prod_sign_i(prod_sign_o),
    .add_sign_i (add_sign_o),
    .z_mag_i    (z_i[MAG_W-1:0]),
    .rnd_mode_i (rnd_mode_i),
    .special_o  (cls_special),
    .invalid_o  (cls_invalid),
    .result_o   (cls_result)
  );

  always_comb begin
    if (nan_hit) begin
      bypass_valid_o  = 1'b1;
      invalid_o       = nan_sig;
      bypass_result_o = nan_val;
    end else begin
      bypass_valid_o  = cls_special;
      invalid_o       = cls_invalid;
      bypass_result_o = cls_result;
    end
  end

  logic any_snan, any_qnan, any_inf;

  always_comb begin
    any_snan = 1'b0;
    any_qnan = 1'b0;
    any_inf  = 1'b0;
    for (int i = 0; i < NUM_OPS; i++) begin
      any_snan |= (op_cls[i] == CLS_SNAN);
      any_qnan |= (op_cls[i] == CLS_QNAN);
      any_inf  |= (op_cls[i] == CLS_INF);
    end
  end

  always_comb begin
    if (any_snan) begin
      AST_SNAN_RAISES_INVALID: assert (invalid_o && bypass_valid_o); // R2
    end
    if (any_qnan && !any_snan) begin
      AST_QNAN_STAYS_SILENT: assert (!invalid_o && bypass_result_o[MAN_W-1]); // R3
    end
    if (invalid_o && !any_snan) begin
      AST_INVALID_GIVES_DEFAULT: assert (bypass_result_o == DEF_NAN); // R4
    end
    if (any_inf || any_qnan || any_snan) begin
      AST_NONFINITE_BYPASSES: assert (bypass_valid_o); // R10
    end
    if (!bypass_valid_o) begin
      AST_DATAPATH_CLEAN: assert (bypass_result_o == '0 && !invalid_o); // R10
    end
  end

endmodule

// File: tb/test_fma_special_resolver.sv
module test_fma_special_resolver;

  logic        clk;
  logic [31:0] x, y, z;
  logic        np, na;
  logic [1:0]  rm;
  logic        bv, inv, ps_o, as_o;
  logic [31:0] res;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  fma_special_resolver i_fma_special_resolver (
    .x_i            (x),
    .y_i            (y),
    .z_i            (z),
    .neg_prod_i     (np),
    .neg_add_i      (na),
    .rnd_mode_i     (rm),
    .bypass_valid_o (bv),
    .bypass_result_o(res),
    .invalid_o      (inv),
    .prod_sign_o    (ps_o),
    .add_sign_o     (as_o)
  );

  localparam logic [31:0] DNAN = 32'h7FC0_0000;

  logic [31:0] pool [12] = '{
    32'h0000_0000, 32'h8000_0000, 32'h0000_0005, 32'h8040_0000,
    32'h3F80_0000, 32'hC040_0000, 32'h7F80_0000, 32'hFF80_0000,
    32'h7FC0_0001, 32'hFFE0_0000, 32'h7F80_0001, 32'hFF90_0000
  };

  function automatic bit f_nan(logic [31:0] v);  return v[30:23] == 8'hFF && v[22:0] != 0; endfunction
  function automatic bit f_snan(logic [31:0] v); return f_nan(v) && !v[22]; endfunction
  function automatic bit f_qnan(logic [31:0] v); return f_nan(v) && v[22]; endfunction
  function automatic bit f_inf(logic [31:0] v);  return v[30:0] == 31'h7F80_0000; endfunction
  function automatic bit f_zero(logic [31:0] v); return v[30:0] == 0; endfunction

  task automatic expect_out(input logic [31:0] xv, yv, zv, input logic npv, nav,
                            input logic [1:0] rmv, output logic e_bv, e_inv,
                            output logic [31:0] e_res, output string tag);
    logic ps, zs;
    ps = xv[31] ^ yv[31] ^ npv;
    zs = zv[31] ^ nav;
    e_bv = 1; e_inv = 0; e_res = 0;
    if (f_snan(zv))      begin e_res = zv | 32'h0040_0000; e_inv = 1; tag = "R2"; end
    else if (f_snan(xv)) begin e_res = xv | 32'h0040_0000; e_inv = 1; tag = "R2"; end
    else if (f_snan(yv)) begin e_res = yv | 32'h0040_0000; e_inv = 1; tag = "R2"; end
    else if (f_qnan(zv)) begin e_res = zv; tag = "R3"; end
    else if (f_qnan(xv)) begin e_res = xv; tag = "R3"; end
    else if (f_qnan(yv)) begin e_res = yv; tag = "R3"; end
    else if ((f_inf(xv) && f_zero(yv)) || (f_zero(xv) && f_inf(yv))) begin
      e_res = DNAN; e_inv = 1; tag = "R4";
    end else if (f_inf(xv) || f_inf(yv)) begin
      if (f_inf(zv) && zs != ps) begin e_res = DNAN; e_inv = 1; tag = "R5"; end
      else begin e_res = {ps, 31'h7F80_0000}; tag = "R6"; end
    end else if (f_zero(xv) || f_zero(yv)) begin
      if (f_zero(zv)) begin
        e_res = (zs == ps) ? {zs, 31'h0} : {rmv == 2'd3, 31'h0};
        tag = "R8";
      end else begin
        e_res = {zs, zv[30:0]}; tag = "R7";
      end
    end else if (f_inf(zv)) begin
      e_res = {zs, 31'h7F80_0000}; tag = "R9";
    end else begin
      e_bv = 0; tag = "R10";
    end
  endtask

  task automatic run_one(input logic [31:0] xv, yv, zv, input logic npv, nav,
                         input logic [1:0] rmv);
    logic e_bv, e_inv;
    logic [31:0] e_res;
    string tag;
    @(posedge clk);
    #1;
    x = xv; y = yv; z = zv; np = npv; na = nav; rm = rmv;
    @(negedge clk);
    expect_out(xv, yv, zv, npv, nav, rmv, e_bv, e_inv, e_res, tag);
    tests_run++;
    if (bv !== e_bv || inv !== e_inv || res !== e_res) begin
      tests_failed++;
      $display("FAIL %s x=%h y=%h z=%h np=%b na=%b rm=%0d: got bv=%b inv=%b res=%h exp bv=%b inv=%b res=%h",
               tag, xv, yv, zv, npv, nav, rmv, bv, inv, res, e_bv, e_inv, e_res);
    end
    tests_run++; // R1 sign outputs
    if (ps_o !== (xv[31] ^ yv[31] ^ npv) || as_o !== (zv[31] ^ nav)) begin
      tests_failed++;
      $display("FAIL R1 got ps=%b as=%b exp ps=%b as=%b", ps_o, as_o,
               xv[31] ^ yv[31] ^ npv, zv[31] ^ nav);
    end
  endtask

  initial begin
    x = 0; y = 0; z = 0; np = 0; na = 0; rm = 0;
    // idle state: all-zero operands give +0 bypass (R8)
    @(negedge clk);
    tests_run++;
    if (bv !== 1'b1 || res !== 32'h0 || inv !== 1'b0) begin
      tests_failed++;
      $display("FAIL R8 idle got bv=%b res=%h inv=%b exp bv=1 res=00000000 inv=0", bv, res, inv);
    end
    // directed: opposite zeros under round-down give -0 (R8), else +0
    run_one(32'h0000_0000, 32'h3F80_0000, 32'h8000_0000, 1'b0, 1'b0, 2'd3);
    run_one(32'h0000_0000, 32'h3F80_0000, 32'h8000_0000, 1'b0, 1'b0, 2'd0);
    // directed: sNaN in y beats qNaN in z (R2)
    run_one(32'h3F80_0000, 32'h7F80_0001, 32'h7FC0_0001, 1'b0, 1'b0, 2'd0);
    // full sweep
    for (int ix = 0; ix < 12; ix++)
      for (int iy = 0; iy < 12; iy++)
        for (int iz = 0; iz < 12; iz++)
          for (int c = 0; c < 16; c++)
            run_one(pool[ix], pool[iy], pool[iz], c[0], c[1], c[3:2]);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog expired: got running exp finished");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

endmodule